// File: doc/BRIEF.md
# Comparator Output Conditioning and Interrupt

This block is the digital back end of an analog comparator. It brings the raw, asynchronous comparator decision into the system clock domain and gates it with an enable. It then applies a selectable polarity inversion. The result can optionally be re-timed so that it only changes on falling edges of a timer clock, after the timer prescaler. A timer that counts on the rising edge then never sees the comparator change while it increments.

Rising and falling transitions of the conditioned output each feed their own detector, and each detector has its own enable. An enabled transition sets a sticky interrupt flag, which software clears with a strobe. A new enabled transition that arrives in the same cycle as the clear keeps the flag set. The interrupt request is the flag gated by an interrupt enable. A change of the output caused by writing the polarity or the enable bit counts as an edge, so the flag can be raised while the comparator is switched off.

The block also drives a 2-bit code that steers the comparator's positive input to one of four sources.

Top module: `cmp_cond`

## Requirements
- R1: With enable=1 and sync mode off, cmpOut equals the synchronized raw input XOR the polarity bit. A change on rawIn reaches cmpOut after two rising clock edges.
- R2: With enable=0 and sync mode off, cmpOut equals the polarity bit whatever rawIn is.
- R3: With sync mode on, cmpOut holds its value and changes only at a rising clock edge where tmrClk is sampled low after having been sampled high at the previous edge. At that edge cmpOut takes the value the non-synced path has.
- R4: A 0-to-1 change of cmpOut sets intFlag at the next rising clock edge when the rising-edge enable is 1, and does not set it when that enable is 0.
- R5: A 1-to-0 change of cmpOut sets intFlag at the next rising clock edge when the falling-edge enable is 1, and does not set it when that enable is 0.
- R6: intFlag stays set until flagClr is high at a rising edge, and it is 0 after that edge if no enabled edge occurs in the same cycle.
- R7: If an enabled edge occurs in the cycle where flagClr is high, intFlag is 1 after that edge.
- R8: A change of cmpOut caused by writing the polarity bit or the enable bit is an edge like any other and can set intFlag, including while the comparator is disabled.
- R9: irq equals intFlag AND the interrupt-enable bit. intFlag sets even while the interrupt enable is 0.
- R10: inSel drives the 2-bit input-select field: 00 external pin, 01 DAC, 10 fixed reference, 11 ground.
- R11: After reset, cmpOut, intFlag, irq and inSel are all 0, and every configuration bit is 0.
- R12: The configuration is written in one cycle with cfgWr=1. In cfgData, bit0 is enable, bit1 polarity, bit2 sync mode, bit3 rising-edge enable, bit4 falling-edge enable, bit5 interrupt enable, and bits 7:6 the input select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawIn | input | 1 | Raw asynchronous comparator decision |
| tmrClk | input | 1 | Post-prescaler timer clock level, sampled on clk |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgData | input | 8 | Configuration word (fields per R12) |
| flagClr | input | 1 | Software clear of the interrupt flag |
| cmpOut | output | 1 | Conditioned comparator output |
| intFlag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |
| inSel | output | 2 | Positive-input source select code |

## Verification
A wrong synchronizer depth or a wrong gating of the enable shows on cmpOut within two or three cycles of a rawIn change or a configuration write. A stale edge-history register shows as a spurious or missing intFlag one cycle after cmpOut moves. A broken re-timing register shows as cmpOut moving on a cycle with no timer falling edge, or failing to move on one. Errors in the flag priority show in the single cycle where a clear and an edge coincide. From then on the flag value persists, so the error stays visible until the next clear.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int SEL_W = 2;
  localparam int CFG_W = 6 + SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] inSel;
    logic             irqEn;
    logic             fallEn;
    logic             riseEn;
    logic             syncMode;
    logic             polarity;
    logic             enable;
  } cfg_t;

  typedef struct packed {
    logic clrFlag;
  } strobe_t;
endpackage

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             flagClr,
  output cfg_t             cfg,
  output strobe_t          strobes
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgWr) cfg <= cfg_t'(cfgData);
  end

  always_comb begin
    strobes = '0;
    strobes.clrFlag = flagClr;
  end

  // R12: a write lands the exact word at the next edge
  a_r12_cfg_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (cfg == cfg_t'($past(cfgData))));
  // R12: without a write the configuration does not move
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable(cfg));
endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rawIn,
  input  logic    tmrClk,
  input  cfg_t    cfg,
  input  strobe_t strobes,
  output logic    cmpOut,
  output logic    intFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  logic gatedIn, directOut;
  logic tmrPrev, tmrFall, syncHeld;
  logic prevOut, riseHit, fallHit;

  assign gatedIn   = cfg.enable & syncChain[LAST];
  assign directOut = gatedIn ^ cfg.polarity;
  assign tmrFall   = tmrPrev & ~tmrClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrPrev  <= 1'b0;
      syncHeld <= 1'b0;
    end else begin
      tmrPrev <= tmrClk;
      if (tmrFall) syncHeld <= directOut;
    end
  end

  assign cmpOut  = cfg.syncMode ? syncHeld : directOut;
  assign riseHit = cfg.riseEn & cmpOut & ~prevOut;
  assign fallHit = cfg.fallEn & ~cmpOut & prevOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= 1'b0;
      intFlag <= 1'b0;
    end else begin
      prevOut <= cmpOut;
      intFlag <= (intFlag & ~strobes.clrFlag) | riseHit | fallHit;
    end
  end

  // R2: a disabled comparator shows only the polarity bit
  a_r2_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !cfg.syncMode) |-> (cmpOut == cfg.polarity));
  // R3: the re-timed value moves only on a timer falling edge
  a_r3_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tmrFall |=> $stable(syncHeld));
  // R6: the flag is sticky without a clear
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !strobes.clrFlag) |=> intFlag);
  // R6: a clear with no edge drops the flag
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag && !riseHit && !fallHit) |=> !intFlag);
  // R7: an enabled edge always leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (riseHit || fallHit) |=> intFlag);
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             tmrClk,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             flagClr,
  output logic             cmpOut,
  output logic             intFlag,
  output logic             irq,
  output logic [SEL_W-1:0] inSel
);
  cfg_t    cfg;
  strobe_t strobes;

  cmp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .flagClr(flagClr), .cfg(cfg), .strobes(strobes)
  );

  cmp_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .tmrClk(tmrClk),
    .cfg(cfg), .strobes(strobes), .cmpOut(cmpOut), .intFlag(intFlag)
  );

  assign irq   = intFlag & cfg.irqEn;
  assign inSel = cfg.inSel;

  // R9: no request without a pending flag
  a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intFlag);
endmodule

// File: tb/test_cmp_cond.sv
module test_cmp_cond;
  logic clk = 1'b0, rstN = 1'b0;
  logic rawIn = 1'b0, tmrClk = 1'b0, cfgWr = 1'b0, flagClr = 1'b0;
  logic [7:0] cfgData = '0;
  logic cmpOut, intFlag, irq;
  logic [1:0] inSel;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cmp_cond i_cmp_cond (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .tmrClk(tmrClk), .cfgWr(cfgWr),
    .cfgData(cfgData), .flagClr(flagClr), .cmpOut(cmpOut),
    .intFlag(intFlag), .irq(irq), .inSel(inSel)
  );

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] mk(logic en, logic pol, logic sy, logic re,
                                    logic fe, logic ie, logic [1:0] sel);
    return {sel, ie, fe, re, sy, pol, en};
  endfunction

  task automatic wcfg(logic [7:0] d);
    cfgWr = 1'b1; cfgData = d;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic clr();
    flagClr = 1'b1;
    step();
    flagClr = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    // R11: reset state
    check("R11 cmpOut", cmpOut, 0);
    check("R11 intFlag", intFlag, 0);
    check("R11 irq", irq, 0);
    check("R11 inSel", inSel, 0);
    rstN = 1'b1;
    step();

    // R1: latency of two edges
    wcfg(mk(1, 0, 0, 0, 0, 0, 0));
    rawIn = 1'b1;
    step();
    check("R1 latency one edge", cmpOut, 0);
    step();
    check("R1 latency two edges", cmpOut, 1);

    // R1 / R2: sweep enable, polarity, raw input
    for (int en = 0; en < 2; en++)
      for (int pol = 0; pol < 2; pol++)
        for (int r = 0; r < 2; r++) begin
          wcfg(mk(en[0], pol[0], 0, 0, 0, 0, 0));
          rawIn = r[0];
          step(3);
          check(en ? "R1 output" : "R2 disabled output", cmpOut,
                2'((r & en) ^ pol));
        end

    // R4 / R5 / R9: edge enable sweep with both directions
    for (int re = 0; re < 2; re++)
      for (int fe = 0; fe < 2; fe++)
        for (int dir = 0; dir < 2; dir++) begin
          wcfg(mk(1, 0, 0, 0, 0, 0, 0));
          rawIn = ~dir[0];
          step(4);
          clr();
          wcfg(mk(1, 0, 0, re[0], fe[0], 0, 0));
          rawIn = dir[0];
          step(3);
          check(dir ? "R4 rising edge flag" : "R5 falling edge flag",
                intFlag, 2'(dir ? re : fe));
          check("R9 irq masked", irq, 0);
        end

    // R9: irq follows the enable once the flag is set
    wcfg(mk(1, 0, 0, 1, 1, 1, 0));
    check("R9 irq enabled", irq, 1);

    // R6: flag holds, then clears
    wcfg(mk(1, 0, 0, 0, 0, 1, 0));
    step(3);
    check("R6 flag holds", intFlag, 1);
    clr();
    check("R6 flag cleared", intFlag, 0);
    check("R9 irq after clear", irq, 0);

    // R8: polarity toggle while disabled sets the flag
    wcfg(mk(0, 0, 0, 1, 1, 0, 0));
    step(2);
    clr();
    wcfg(mk(0, 1, 0, 1, 1, 0, 0));
    check("R8 pol toggle output", cmpOut, 1);
    step();
    check("R8 pol toggle flag", intFlag, 1);
    // R7: edge in the cycle of the clear keeps the flag
    wcfg(mk(0, 0, 0, 1, 1, 0, 0));
    flagClr = 1'b1;
    step();
    flagClr = 1'b0;
    check("R7 set wins over clear", intFlag, 1);
    clr();
    check("R7 plain clear", intFlag, 0);

    // R8: enable toggle with raw input high
    rawIn = 1'b1;
    step(3);
    wcfg(mk(1, 0, 0, 1, 0, 0, 0));
    step();
    check("R8 enable toggle flag", intFlag, 1);
    clr();

    // R3: re-timing to the timer falling edge
    wcfg(mk(1, 0, 1, 0, 0, 0, 0));
    check("R3 held before timer edge", cmpOut, 0);
    tmrClk = 1'b1;
    step(2);
    check("R3 held while timer high", cmpOut, 0);
    tmrClk = 1'b0;
    step();
    check("R3 captured at timer fall", cmpOut, 1);
    rawIn = 1'b0;
    step(3);
    check("R3 held after raw change", cmpOut, 1);
    tmrClk = 1'b1;
    step();
    check("R3 no capture on timer rise", cmpOut, 1);
    tmrClk = 1'b0;
    step();
    check("R3 second capture", cmpOut, 0);

    // R10 / R12: input select codes
    for (int s = 0; s < 4; s++) begin
      wcfg(mk(1, 0, 0, 0, 0, 0, 2'(s)));
      check("R10 input select", inSel, 2'(s));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule